// File: doc/BRIEF.md
# Sensitivity-Matrix Voltage Fitness Evaluator

This block scores one candidate solution of a genetic search that regulates feeder voltages. A candidate (chromosome) holds one 16-bit field per controllable node. Each field carries a signed reactive-power setting for the node's generator and a signed count of switched capacitor banks. The block turns the fields into a vector of reactive-power changes in kvar. It multiplies that vector by a constant voltage-sensitivity matrix held in on-chip memory, which gives predicted voltage increments. It adds the increments to the measured node voltages. It then sums each node's absolute deviation from nominal, weighted by a penalty that grows in steps once the node leaves the allowed band. A lower result is a better candidate.

The matrix is written one row at a time through a simple write port. An evaluation starts with a one-cycle `start`. The matrix is then swept one row per clock, with one multiply lane per column. The objective appears with a one-cycle `out_valid` pulse and is held until the next result. Voltages use a signed 16-bit fixed-point format in which 1.0 p.u. equals 16384. Power limits are not checked here; only the voltage penalty enters the score.

Top module: `volt_fitness_eval`

## Requirements
- R1: Node i occupies `chrom[16i+15:16i]`. Bit 15 is the sign of the generator setting and bits 14:5 its magnitude in kvar. Bit 4 is the sign of the bank count and bits 3:0 its magnitude. Both fields are sign-magnitude, and a negative zero counts as zero.
- R2: The reactive change of a node is its generator setting plus 25 kvar times its signed bank count.
- R3: The increment of node i is the sum over j of coefficient[i][j] times change[j], arithmetically shifted right by 10 (rounding toward minus infinity), then saturated to the signed 16-bit range.
- R4: The predicted voltage is the measured voltage plus the increment, saturated to signed 16 bits. The deviation is the absolute difference from 16384.
- R5: The penalty weight is 1 for a deviation up to 819 (0.05 p.u.), 4 for a deviation from 820 up to 1310 (0.08 p.u.), and 16 above 1310.
- R6: `obj` is the sum over all nodes of weight times deviation.
- R7: `out_valid` is a single-cycle pulse N_NODES+3 cycles after the edge that accepted `start`. `obj` changes only together with that pulse and holds otherwise.
- R8: `start` is accepted only when no evaluation is in flight. It is ignored from the accepting edge through the edge that raises `out_valid`, and a start on the following edge is accepted.
- R9: With `mat_we` high, row `mat_addr` of the matrix is written from `mat_wdata`, with coefficient j in bits [16j+15:16j]. Later evaluations use the new row.
- R10: While `rst` is high, `out_valid` is 0 and `obj` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mat_we | input | 1 | Matrix row write enable |
| mat_addr | input | AW | Row being written |
| mat_wdata | input | N_NODES*COEF_W | Row coefficients, signed |
| start | input | 1 | Begin scoring the presented chromosome |
| chrom | input | N_NODES*(DG_W+CAP_W) | Chromosome fields, one per node |
| v_meas | input | N_NODES*V_W | Measured node voltages, signed fixed point |
| out_valid | output | 1 | Objective is new this cycle |
| obj | output | OBJ_W | Weighted deviation sum |

## Verification
Single-node impulses against a diagonal matrix separate the sign handling, negative zero and bank scaling from each other. An off-diagonal matrix with negative coefficients and tiny products exposes column order and the floor in the shift. Voltages placed exactly on both sides of each band edge, above and below nominal, pin the penalty steps. Extreme fields and voltages drive both saturation points. Overlapping and held starts test acceptance. Randomised matrices, chromosomes and voltages are compared against a behavioural model on every clock.

// File: rtl/vfe_pkg.sv
package vfe_pkg;

  typedef enum logic [1:0] {
    BAND_IN   = 2'd0,
    BAND_NEAR = 2'd1,
    BAND_FAR  = 2'd2
  } band_e;

  // Penalty weight expressed as a left shift: x1, x4, x16 (R5)
  function automatic int band_shift(band_e b);
    case (b)
      BAND_NEAR: return 2;
      BAND_FAR:  return 4;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/vfe_decode.sv
module vfe_decode #(
  parameter int N_NODES   = 4,
  parameter int DG_W      = 11,
  parameter int CAP_W     = 5,
  parameter int BANK_KVAR = 25,
  parameter int Q_W       = 16
) (
  input  logic [N_NODES*(DG_W+CAP_W)-1:0] chrom,
  output logic [N_NODES*Q_W-1:0]          q_flat
);
  localparam int FW = DG_W + CAP_W;

  for (genvar gi = 0; gi < N_NODES; gi++) begin : g_node
    logic              dg_neg, cap_neg;
    logic [DG_W-2:0]   dg_mag;
    logic [CAP_W-2:0]  cap_cnt;
    logic [Q_W-1:0]    cap_kvar;
    logic signed [Q_W-1:0] dg_val, cap_val;

    assign dg_neg  = chrom[gi*FW + FW-1];
    assign dg_mag  = chrom[gi*FW + CAP_W +: DG_W-1];
    assign cap_neg = chrom[gi*FW + CAP_W-1];
    assign cap_cnt = chrom[gi*FW +: CAP_W-1];

    // R1 sign-magnitude fields, R2 bank scaling
    always_comb begin
      cap_kvar = Q_W'(cap_cnt) * Q_W'(BANK_KVAR);
      dg_val   = dg_neg  ? -$signed(Q_W'(dg_mag)) : $signed(Q_W'(dg_mag));
      cap_val  = cap_neg ? -$signed(cap_kvar)     : $signed(cap_kvar);
    end

    assign q_flat[gi*Q_W +: Q_W] = dg_val + cap_val;
  end

endmodule

// File: rtl/vfe_coef_mem.sv
module vfe_coef_mem #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 64,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ROW_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [ROW_W-1:0] rdata
);
  logic [ROW_W-1:0] mem [DEPTH];

  // Simple dual-port RAM with registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/vfe_row_mac.sv
module vfe_row_mac #(
  parameter int N_NODES    = 4,
  parameter int COEF_W     = 16,
  parameter int Q_W        = 16,
  parameter int V_W        = 16,
  parameter int COEF_SHIFT = 10
) (
  input  logic [N_NODES*COEF_W-1:0] row,
  input  logic [N_NODES*Q_W-1:0]    q_flat,
  output logic signed [V_W-1:0]     dv
);
  localparam int P_W   = COEF_W + Q_W;
  localparam int ACC_W = P_W + $clog2(N_NODES) + 1;
  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-V_W+1){1'b0}}, {(V_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

  logic signed [P_W-1:0]   prod [N_NODES];
  logic signed [ACC_W-1:0] acc, scaled;

  // One multiply lane per matrix column
  for (genvar gi = 0; gi < N_NODES; gi++) begin : g_lane
    assign prod[gi] = P_W'($signed(row[gi*COEF_W +: COEF_W])) *
                      P_W'($signed(q_flat[gi*Q_W +: Q_W]));
  end

  // R3 adder tree, floor shift, saturation
  always_comb begin
    acc = '0;
    for (int i = 0; i < N_NODES; i++) acc = acc + ACC_W'(prod[i]);
    scaled = acc >>> COEF_SHIFT;
    if (scaled > SAT_HI)      dv = SAT_HI[V_W-1:0];
    else if (scaled < SAT_LO) dv = SAT_LO[V_W-1:0];
    else                      dv = scaled[V_W-1:0];
  end

endmodule

// File: rtl/vfe_penalty.sv
module vfe_penalty
  import vfe_pkg::*;
#(
  parameter int V_W     = 16,
  parameter int TERM_W  = 21,
  parameter int V_NOM   = 16384,
  parameter int TH_NEAR = 819,
  parameter int TH_FAR  = 1310
) (
  input  logic signed [V_W-1:0] v,
  input  logic signed [V_W-1:0] dv,
  output logic [TERM_W-1:0]     term
);
  localparam logic signed [V_W:0]   VMAX  = {2'b00, {(V_W-1){1'b1}}};
  localparam logic signed [V_W:0]   VMIN  = {2'b11, {(V_W-1){1'b0}}};
  localparam logic signed [V_W+1:0] NOM_X = (V_W+2)'(V_NOM);
  localparam logic [V_W:0]          TN    = (V_W+1)'(TH_NEAR);
  localparam logic [V_W:0]          TF    = (V_W+1)'(TH_FAR);

  logic signed [V_W:0]   vsum;
  logic signed [V_W-1:0] vp;
  logic signed [V_W+1:0] diff;
  logic [V_W:0]          dev;
  band_e                 band;

  always_comb begin
    vsum = {v[V_W-1], v} + {dv[V_W-1], dv};                     // R4
    if (vsum > VMAX)      vp = VMAX[V_W-1:0];
    else if (vsum < VMIN) vp = VMIN[V_W-1:0];
    else                  vp = vsum[V_W-1:0];
    diff = {vp[V_W-1], vp[V_W-1], vp} - NOM_X;
    dev  = diff[V_W+1] ? (V_W+1)'(-diff) : (V_W+1)'(diff);
    if (dev <= TN)      band = BAND_IN;                          // R5
    else if (dev <= TF) band = BAND_NEAR;
    else                band = BAND_FAR;
    term = TERM_W'(dev) << band_shift(band);
  end

endmodule

// File: rtl/volt_fitness_eval.sv
module volt_fitness_eval #(
  parameter int N_NODES    = 4,
  parameter int DG_W       = 11,
  parameter int CAP_W      = 5,
  parameter int BANK_KVAR  = 25,
  parameter int COEF_W     = 16,
  parameter int COEF_SHIFT = 10,
  parameter int V_W        = 16,
  parameter int V_NOM      = 16384,
  parameter int TH_NEAR    = 819,
  parameter int TH_FAR     = 1310,
  parameter int AW         = $clog2(N_NODES),
  parameter int OBJ_W      = V_W + 6 + $clog2(N_NODES)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            mat_we,
  input  logic [AW-1:0]                   mat_addr,
  input  logic [N_NODES*COEF_W-1:0]       mat_wdata,
  input  logic                            start,
  input  logic [N_NODES*(DG_W+CAP_W)-1:0] chrom,
  input  logic [N_NODES*V_W-1:0]          v_meas,
  output logic                            out_valid,
  output logic [OBJ_W-1:0]                obj
);
  localparam int Q_W    = DG_W + CAP_W;
  localparam int ROW_W  = N_NODES * COEF_W;
  localparam int TERM_W = V_W + 5;
  localparam logic [AW-1:0] LAST = AW'(N_NODES - 1);

  logic [N_NODES*Q_W-1:0] q_dec, q_r;
  logic [N_NODES*V_W-1:0] v_r;
  logic [ROW_W-1:0]       row_data;
  logic                   busy, s1_v, s2_v, s3_v, idle;
  logic [AW-1:0]          rd_addr, s1_row, s2_row, s3_row;
  logic signed [V_W-1:0]  mac_dv, s2_dv;
  logic [TERM_W-1:0]      pen_term, s3_term;
  logic [OBJ_W-1:0]       acc, acc_next;

  vfe_decode #(.N_NODES(N_NODES), .DG_W(DG_W), .CAP_W(CAP_W),
               .BANK_KVAR(BANK_KVAR), .Q_W(Q_W)) u_dec (
    .chrom(chrom), .q_flat(q_dec));

  vfe_coef_mem #(.DEPTH(N_NODES), .ROW_W(ROW_W), .AW(AW)) u_mem (
    .clk(clk), .we(mat_we), .waddr(mat_addr), .wdata(mat_wdata),
    .raddr(rd_addr), .rdata(row_data));

  vfe_row_mac #(.N_NODES(N_NODES), .COEF_W(COEF_W), .Q_W(Q_W),
                .V_W(V_W), .COEF_SHIFT(COEF_SHIFT)) u_mac (
    .row(row_data), .q_flat(q_r), .dv(mac_dv));

  vfe_penalty #(.V_W(V_W), .TERM_W(TERM_W), .V_NOM(V_NOM),
                .TH_NEAR(TH_NEAR), .TH_FAR(TH_FAR)) u_pen (
    .v($signed(v_r[s2_row*V_W +: V_W])), .dv(s2_dv), .term(pen_term));

  // R8 a new evaluation waits for the whole pipe to drain
  assign idle     = !busy && !s1_v && !s2_v && !s3_v;
  assign acc_next = ((s3_row == '0) ? '0 : acc) + OBJ_W'(s3_term);   // R6

  always_ff @(posedge clk) begin
    if (rst) begin                                                   // R10
      busy      <= 1'b0;
      rd_addr   <= '0;
      q_r       <= '0;
      v_r       <= '0;
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      s3_v      <= 1'b0;
      s1_row    <= '0;
      s2_row    <= '0;
      s3_row    <= '0;
      s2_dv     <= '0;
      s3_term   <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      obj       <= '0;
    end else begin
      out_valid <= 1'b0;
      if (start && idle) begin
        q_r     <= q_dec;
        v_r     <= v_meas;
        busy    <= 1'b1;
        rd_addr <= '0;
      end else if (busy) begin
        rd_addr <= rd_addr + 1'b1;
        if (rd_addr == LAST) busy <= 1'b0;
      end
      // stage 1: row read out of memory
      s1_v    <= busy;
      s1_row  <= rd_addr;
      // stage 2: row dot product
      s2_v    <= s1_v;
      s2_row  <= s1_row;
      s2_dv   <= mac_dv;
      // stage 3: weighted deviation
      s3_v    <= s2_v;
      s3_row  <= s2_row;
      s3_term <= pen_term;
      // stage 4: accumulate, publish on last row (R7)
      if (s3_v) begin
        if (s3_row == LAST) begin
          obj       <= acc_next;
          out_valid <= 1'b1;
        end else begin
          acc <= acc_next;
        end
      end
    end
  end

endmodule

// File: rtl/vfe_checker.sv
module vfe_checker #(
  parameter int N_NODES = 4,
  parameter int OBJ_W   = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             out_valid,
  input logic [OBJ_W-1:0] obj
);
  localparam int CMAX = N_NODES + 4;
  localparam int CW   = $clog2(CMAX + 1);

  // cycles elapsed since an accepted start, 0 when nothing is in flight
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                                cnt <= '0;
    else if (cnt == '0 || cnt == CW'(CMAX)) cnt <= start ? CW'(1) : '0;
    else                                    cnt <= cnt + 1'b1;
  end

  p_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(obj) |-> out_valid);

  p_schedule_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid == (cnt == CW'(CMAX)));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && obj == '0));

endmodule

bind volt_fitness_eval vfe_checker #(.N_NODES(N_NODES), .OBJ_W(OBJ_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .out_valid(out_valid), .obj(obj));

// File: tb/sim_volt_fitness_eval.sv
module sim_volt_fitness_eval;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mat_we = 1'b0;
  logic [1:0]  mat_addr = '0;
  logic [63:0] mat_wdata = '0;
  logic        start = 1'b0;
  logic [63:0] chrom = '0;
  logic [63:0] v_meas = '0;
  logic        out_valid;
  logic [23:0] obj;

  int n_tests = 0;
  int n_fail  = 0;
  bit fin     = 0;

  always #4 clk = ~clk;

  volt_fitness_eval u0 (
    .clk(clk), .rst(rst), .mat_we(mat_we), .mat_addr(mat_addr),
    .mat_wdata(mat_wdata), .start(start), .chrom(chrom),
    .v_meas(v_meas), .out_valid(out_valid), .obj(obj));

  int coefm [N][N];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fld(int dg, int cap);
    logic [15:0] f;
    f[15]   = (dg < 0);
    f[14:5] = 10'(dg < 0 ? -dg : dg);
    f[4]    = (cap < 0);
    f[3:0]  = 4'(cap < 0 ? -cap : cap);
    return f;
  endfunction

  function automatic logic [63:0] p4(logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [15:0] d);
    return {d, c, b, a};
  endfunction

  // behavioural score from the requirements
  function automatic longint ref_obj();
    longint q [N];
    longint total = 0;
    for (int j = 0; j < N; j++) begin
      logic [15:0] f = chrom[16*j +: 16];
      longint dg  = longint'(f[14:5]);
      longint cap = longint'(f[3:0]);
      if (f[15]) dg = -dg;
      if (f[4])  cap = -cap;
      q[j] = dg + 25 * cap;
    end
    for (int i = 0; i < N; i++) begin
      longint s = 0, dv, vp, dev;
      for (int j = 0; j < N; j++) s += longint'(coefm[i][j]) * q[j];
      dv = s >>> 10;
      if (dv > 32767) dv = 32767;
      if (dv < -32768) dv = -32768;
      vp = longint'($signed(v_meas[16*i +: 16])) + dv;
      if (vp > 32767) vp = 32767;
      if (vp < -32768) vp = -32768;
      dev = vp - 16384;
      if (dev < 0) dev = -dev;
      if (dev <= 819)       total += dev;
      else if (dev <= 1310) total += 4 * dev;
      else                  total += 16 * dev;
    end
    return total;
  endfunction

  // cycle model: acceptance and due time of each result
  int     cyc = 0;
  int     last_acc = -1000;
  longint exp_q [$];
  int     due_q [$];
  longint hold = 0;
  bit     ev;

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0;
      last_acc = -1000;
      exp_q.delete();
      due_q.delete();
    end else begin
      if (start && cyc >= last_acc + N + 4) begin
        last_acc = cyc;
        exp_q.push_back(ref_obj());
        due_q.push_back(cyc + N + 4);
      end
      cyc = cyc + 1;
    end
  end

  always @(negedge clk) begin
    if (rst) hold = 0;
    else if (!fin) begin
      ev = (due_q.size() > 0) && (due_q[0] == cyc);
      chk(out_valid == ev, "R7 valid timing", longint'(out_valid), longint'(ev));
      if (ev) begin
        hold = exp_q.pop_front();
        void'(due_q.pop_front());
      end
      chk(longint'(obj) == hold, "R6 objective", longint'(obj), hold);
    end
  end

  task automatic wrow(input int r, input int c0, input int c1, input int c2, input int c3);
    @(negedge clk);
    mat_we    = 1'b1;
    mat_addr  = 2'(r);
    mat_wdata = {16'(c3), 16'(c2), 16'(c1), 16'(c0)};
    coefm[r][0] = c0; coefm[r][1] = c1; coefm[r][2] = c2; coefm[r][3] = c3;
    @(negedge clk);
    mat_we = 1'b0;
  endtask

  task automatic diag();
    for (int r = 0; r < N; r++)
      wrow(r, r == 0 ? 1024 : 0, r == 1 ? 1024 : 0, r == 2 ? 1024 : 0, r == 3 ? 1024 : 0);
  endtask

  task automatic eval(input logic [63:0] c, input logic [63:0] v, input longint exp, input string tag);
    @(negedge clk);
    chrom = c; v_meas = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N + 3) @(negedge clk);
    chk(out_valid == 1'b1, tag, longint'(out_valid), 1);
    chk(longint'(obj) == exp, tag, longint'(obj), exp);
  endtask

  localparam logic [63:0] VNOM = {4{16'd16384}};
  int seed = 32'h1234_5678;

  function automatic int rnd(int lo, int hi);
    seed = seed * 1103515245 + 12345;
    return lo + int'((seed >>> 8) & 32'h7fff_ffff) % (hi - lo + 1);
  endfunction

  initial begin
    int pulses;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && obj == '0, "R10 reset state", longint'(obj), 0);
    rst = 1'b0;

    diag();
    eval('0, VNOM, 0, "R6 all zero");
    eval(p4(fld(5, 0), 0, 0, 0), VNOM, 5, "R1 positive dg");
    eval(p4(fld(-5, 0), 0, 0, 0), VNOM, 5, "R1 negative dg");
    eval(p4(0, 0, 16'h8010, 0), VNOM, 0, "R1 negative zero");
    eval(p4(0, fld(0, 3), 0, fld(0, -2)), VNOM, 125, "R2 bank scaling");
    eval(p4(fld(100, -4), 0, fld(7, 1), 0), VNOM, 32, "R2 dg plus banks");

    wrow(0, 3, 0, 0, 0);
    eval(p4(fld(-1, 0), 0, 0, 0), VNOM, 1, "R3 floor negative");
    eval(p4(fld(1, 0), 0, 0, 0), VNOM, 0, "R3 floor positive");
    wrow(1, 512, 1024, -2048, 0);
    eval(p4(fld(10, 0), fld(6, 0), fld(1, 0), 0), VNOM, 10, "R9 column order");

    diag();
    eval('0, p4(16'd17203, 16'd15564, 16'd17694, 16'd15073), 30315, "R5 band edges");

    for (int r = 0; r < N; r++) wrow(r, 32767, 32767, 32767, 32767);
    eval({4{fld(1023, 15)}}, VNOM, 1048512, "R3 R4 positive saturation");
    eval({4{fld(-1023, -15)}}, VNOM, 2097152, "R3 negative saturation");
    eval({4{fld(-1023, -15)}}, {4{16'hFF9C}}, 3145728, "R4 voltage saturation");

    diag();
    eval(p4(0, 0, fld(3, 0), 0), VNOM, 3, "R9 before rewrite");
    wrow(2, 0, 0, 2048, 0);
    eval(p4(0, 0, fld(3, 0), 0), VNOM, 6, "R9 after rewrite");

    // R8 second start inside the busy window is dropped
    pulses = 0;
    @(negedge clk); chrom = p4(fld(9, 0), 0, 0, 0); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2 * N + 8) begin @(negedge clk); if (out_valid) pulses++; end
    chk(pulses == 1, "R8 overlapping start", pulses, 1);

    // R8 held start: accepted again right after the result edge
    pulses = 0;
    @(negedge clk); start = 1'b1;
    repeat (2 * (N + 4)) begin @(negedge clk); if (out_valid) pulses++; end
    start = 1'b0;
    repeat (N + 8) begin @(negedge clk); if (out_valid) pulses++; end
    chk(pulses == 2, "R8 back-to-back", pulses, 2);

    for (int k = 0; k < 20; k++) begin
      longint e;
      for (int r = 0; r < N; r++)
        wrow(r, rnd(-2048, 2047), rnd(-2048, 2047), rnd(-2048, 2047), rnd(-2048, 2047));
      chrom  = p4(fld(rnd(-1023, 1023), rnd(-15, 15)), fld(rnd(-1023, 1023), rnd(-15, 15)),
                  fld(rnd(-1023, 1023), rnd(-15, 15)), fld(rnd(-1023, 1023), rnd(-15, 15)));
      v_meas = p4(16'(rnd(14884, 17884)), 16'(rnd(14884, 17884)),
                  16'(rnd(14884, 17884)), 16'(rnd(14884, 17884)));
      e = ref_obj();
      eval(chrom, v_meas, e, "R6 random");
    end

    repeat (4) @(negedge clk);
    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule